// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five software localities owns a memory-mapped security-module interface at any moment. Each locality reaches its own byte-wide access register through a 4 KiB window. A locality asks for ownership by setting a request bit. The block grants a single owner and tells that owner when other localities are waiting. The owner hands the interface back by writing the active bit of its own access register.

The block sits on a simple register bus. A write takes effect at the clock edge where it is presented, and reads are combinational. Besides read data, it drives the identity of the current owner to the command path. It also drives a one-cycle locality-changed pulse to the interrupt logic.

Top module: `loc_arb`

## Requirements
- R1: After reset no locality is active, `loc_chg_o` is 0 and `act_loc_o` is 0. Every access-register read returns bit 7 (valid) as 1. The access register of an idle, non-requesting locality reads 0x80.
- R2: Locality n's access register sits at address n*0x1000 (address bits 15:12 = n, bits 11:0 = 0) for n in 0..4. Writes to any other address are ignored, and reads of any other address return 0x00.
- R3: While no locality is active, a write with bit 1 (request) set grants ownership at that same clock edge. The grant goes to the highest-numbered locality among all outstanding requests, including the one just written.
- R4: The owner's access register reads with bit 7 and bit 5 (active) set. Every other locality's access register reads bit 5 as 0.
- R5: A request write from the locality that already owns the interface is ignored. The owner stays the same, and no request is recorded for it.
- R6: A non-owner with an outstanding request reads bit 1 as 1 in its own register. The owner's register reads bit 2 (pending) as 1 exactly while some other locality has an outstanding request.
- R7: When the owner writes a 1 to bit 5, it gives up ownership at that edge. The same write from a non-owner is ignored.
- R8: After a release, the highest-numbered pending locality is granted on the following clock edge. With nothing pending, the block stays idle.
- R9: `loc_chg_o` is high for exactly one cycle after each edge where ownership changes: a grant, a release, or a switch to another locality. It is low at all other times.
- R10: While idle, `act_loc_o` keeps the number of the last owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 16 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address |
| act_vld_o | output | 1 | Some locality owns the interface |
| act_loc_o | output | 3 | Number of the owning (or last) locality |
| loc_chg_o | output | 1 | One-cycle pulse after an ownership change |

## Verification
The bench targets the hand-over cases.

A release with several localities waiting must hand over to the highest-numbered one, and only one cycle later. A design that grants on the release edge would show no idle cycle and lose the change pulse. A design that picks by arrival order would choose locality 0 instead of 3.

An owner that writes request and release together, or re-requests while it holds the interface, must neither keep ownership nor queue itself. A wrong design would leave a phantom request that gets re-granted after the release.

Writes with a non-zero offset and writes to window 5 are also exercised. A loose decoder would alias them onto a real locality and grant it.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  // access register bit positions (software decodes these)
  localparam int unsigned VLD_BIT  = 7;
  localparam int unsigned ACT_BIT  = 5;
  localparam int unsigned PEND_BIT = 2;
  localparam int unsigned REQ_BIT  = 1;
endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode #(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned LOC_SHIFT = 12,
  localparam int unsigned LOC_W    = $clog2(NUM_LOC)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [LOC_W-1:0]  loc_o
);
  localparam int unsigned FLD_W = ADDR_W - LOC_SHIFT;

  logic [FLD_W-1:0] fld;

  assign fld   = addr_i[ADDR_W-1:LOC_SHIFT];
  assign hit_o = (addr_i[LOC_SHIFT-1:0] == '0) && (32'(fld) < 32'(NUM_LOC));
  assign loc_o = fld[LOC_W-1:0];
endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
  parameter int unsigned N = 5,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] oh_o
);
  // highest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_oh
    assign oh_o[g] = any_o && (idx_o == W'(g));
  end
endmodule

// File: rtl/loc_arb_rdmux.sv
module loc_arb_rdmux #(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned LOC_W  = $clog2(NUM_LOC)
) (
  input  logic               rd_hit_i,
  input  logic [LOC_W-1:0]   rd_loc_i,
  input  logic               act_vld_i,
  input  logic [LOC_W-1:0]   act_loc_i,
  input  logic [NUM_LOC-1:0] req_i,
  output logic [DATA_W-1:0]  rdata_o
);
  import loc_arb_pkg::*;

  logic is_owner;

  assign is_owner = act_vld_i && (act_loc_i == rd_loc_i);

  always_comb begin
    rdata_o = '0;
    if (rd_hit_i) begin
      rdata_o[VLD_BIT]  = 1'b1;
      rdata_o[ACT_BIT]  = is_owner;
      rdata_o[PEND_BIT] = is_owner && (|req_i);
      rdata_o[REQ_BIT]  = req_i[rd_loc_i];
    end
  end
endmodule

// File: rtl/loc_arb.sv
module loc_arb #(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOC_SHIFT = 12,
  localparam int unsigned LOC_W    = $clog2(NUM_LOC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              act_vld_o,
  output logic [LOC_W-1:0]  act_loc_o,
  output logic              loc_chg_o
);
  import loc_arb_pkg::*;

  logic               hit;
  logic [LOC_W-1:0]   sel_loc;
  logic               wr_hit, own_wr, rel;
  logic [NUM_LOC-1:0] req_q, req_d, set_req, req_m, gnt_oh;
  logic               gnt_any;
  logic [LOC_W-1:0]   gnt_idx;
  logic               act_vld_q, act_vld_d, chg_q, chg_d;
  logic [LOC_W-1:0]   act_loc_q, act_loc_d;

  loc_arb_decode #(
    .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .loc_o(sel_loc)
  );

  assign wr_hit = wr_en_i && hit;
  assign own_wr = wr_hit && act_vld_q && (act_loc_q == sel_loc);
  assign rel    = own_wr && wdata_i[ACT_BIT];

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_set
    assign set_req[g] = wr_hit && !own_wr && wdata_i[REQ_BIT] && (sel_loc == LOC_W'(g));
  end

  assign req_m = req_q | set_req;

  loc_arb_pick #(.N(NUM_LOC)) u_pick (
    .req_i(req_m), .any_o(gnt_any), .idx_o(gnt_idx), .oh_o(gnt_oh)
  );

  always_comb begin
    act_vld_d = act_vld_q;
    act_loc_d = act_loc_q;
    req_d     = req_m;
    if (act_vld_q) begin
      if (rel) act_vld_d = 1'b0;
    end else if (gnt_any) begin
      act_vld_d = 1'b1;
      act_loc_d = gnt_idx;
      req_d     = req_m & ~gnt_oh;
    end
  end

  assign chg_d = (act_vld_d != act_vld_q) || (act_vld_d && (act_loc_d != act_loc_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q     <= '0;
      act_vld_q <= 1'b0;
      act_loc_q <= '0;
      chg_q     <= 1'b0;
    end else begin
      req_q     <= req_d;
      act_vld_q <= act_vld_d;
      act_loc_q <= act_loc_d;
      chg_q     <= chg_d;
    end
  end

  loc_arb_rdmux #(.NUM_LOC(NUM_LOC), .DATA_W(DATA_W)) u_rd (
    .rd_hit_i (rd_en_i && hit),
    .rd_loc_i (sel_loc),
    .act_vld_i(act_vld_q),
    .act_loc_i(act_loc_q),
    .req_i    (req_q),
    .rdata_o  (rdata_o)
  );

  assign act_vld_o = act_vld_q;
  assign act_loc_o = act_loc_q;
  assign loc_chg_o = chg_q;
endmodule

// File: rtl/loc_arb_chk.sv
module loc_arb_chk #(
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned LOC_SHIFT = 12,
  localparam int unsigned LOC_W    = $clog2(NUM_LOC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              act_vld_o,
  input logic [LOC_W-1:0]  act_loc_o,
  input logic              loc_chg_o
);
  import loc_arb_pkg::*;

  logic a_hit, a_own;

  assign a_hit = (addr_i[LOC_SHIFT-1:0] == '0) &&
                 (32'(addr_i[ADDR_W-1:LOC_SHIFT]) < 32'(NUM_LOC));
  assign a_own = a_hit && act_vld_o &&
                 (32'(addr_i[ADDR_W-1:LOC_SHIFT]) == 32'(act_loc_o));

  // R1
  valid_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && a_hit) |-> rdata_o[VLD_BIT]);

  // R3
  idle_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_hit && wdata_i[REQ_BIT] && !act_vld_o) |=> act_vld_o);

  // R4
  owner_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && a_own) |-> (rdata_o[VLD_BIT] && rdata_o[ACT_BIT]));

  // R5
  own_req_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_own && !wdata_i[ACT_BIT]) |=> (act_vld_o && $stable(act_loc_o)));

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && a_own && wdata_i[ACT_BIT]) |=> !act_vld_o);

  // R9
  loc_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_chg_o == ((act_vld_o != $past(act_vld_o)) ||
                  (act_vld_o && (act_loc_o != $past(act_loc_o)))));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_vld_o |-> $stable(act_loc_o));
endmodule

bind loc_arb loc_arb_chk #(
  .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOC_SHIFT(LOC_SHIFT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .act_vld_o(act_vld_o), .act_loc_o(act_loc_o), .loc_chg_o(loc_chg_o)
);

// File: tb/loc_arb_tb_top.sv
module loc_arb_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        act_vld_o;
  logic [2:0]  act_loc_o;
  logic        loc_chg_o;

  typedef struct {
    bit         kind;   // 0: read data, 1: state {vld,chg,loc}
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  logic  mon_go = 1'b0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always #5 clk_i = ~clk_i;

  loc_arb dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .act_vld_o(act_vld_o), .act_loc_o(act_loc_o), .loc_chg_o(loc_chg_o)
  );

  // monitor
  always @(negedge clk_i) begin
    if (mon_go && q.size() > 0) begin
      item_t it;
      logic [7:0] got;
      it  = q.pop_front();
      got = it.kind ? {3'b000, act_vld_o, loc_chg_o, act_loc_o} : rdata_o;
      n_chk++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got 0x%02h expected 0x%02h (%s)", it.tag, got, it.exp,
                 it.kind ? "vld,chg,loc" : "rdata");
      end
    end
  end

  task automatic wr_raw(logic [15:0] a, logic [7:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic wr(int loc, logic [7:0] d);
    wr_raw(16'(loc << 12), d);
  endtask

  task automatic rd_raw(logic [15:0] a, logic [7:0] e, string tag);
    item_t it;
    it.kind = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    rd_en_i = 1'b1; addr_i = a; mon_go = 1'b1;
    @(negedge clk_i); #1;
    rd_en_i = 1'b0; addr_i = '0; mon_go = 1'b0;
  endtask

  task automatic rd(int loc, logic [7:0] e, string tag);
    rd_raw(16'(loc << 12), e, tag);
  endtask

  task automatic chk(bit v, int loc, bit c, string tag);
    item_t it;
    it.kind = 1'b1; it.exp = {3'b000, v, c, 3'(loc)}; it.tag = tag;
    q.push_back(it);
    mon_go = 1'b1;
    @(negedge clk_i); #1;
    mon_go = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk(0, 0, 0, "R1 reset idle");
    rd(0, 8'h80, "R1 valid loc0");
    rd(4, 8'h80, "R1 valid loc4");
    // idle grant
    wr(2, 8'h02);
    chk(1, 2, 1, "R3 idle grant");
    rd(2, 8'hA0, "R4 owner read");
    rd(1, 8'h80, "R4 non-owner read");
    // owner re-request
    wr(2, 8'h02);
    chk(1, 2, 0, "R5 owner request ignored");
    rd(2, 8'hA0, "R5 no self request");
    // pending
    wr(0, 8'h02);
    rd(2, 8'hA4, "R6 owner sees pending");
    rd(0, 8'h82, "R6 requester bit");
    wr(4, 8'h02);
    rd(4, 8'h82, "R6 second requester");
    // non-owner release
    wr(0, 8'h20);
    chk(1, 2, 0, "R7 non-owner release ignored");
    rd(0, 8'h82, "R7 request kept");
    // release and hand-over
    wr(2, 8'h20);
    chk(0, 2, 1, "R7 release");
    chk(1, 4, 1, "R8 highest pending granted");
    rd(4, 8'hA4, "R8 new owner pending");
    wr(4, 8'h20);
    chk(0, 4, 1, "R9 release pulse");
    chk(1, 0, 1, "R8 last pending granted");
    rd(0, 8'hA0, "R6 no pending left");
    wr(0, 8'h20);
    chk(0, 0, 1, "R9 release pulse idle");
    chk(0, 0, 0, "R8 stays idle");
    // decode
    wr_raw(16'h5000, 8'h02);
    chk(0, 0, 0, "R2 window 5 write ignored");
    rd_raw(16'h5000, 8'h00, "R2 window 5 reads zero");
    wr_raw(16'h1004, 8'h02);
    chk(0, 0, 0, "R2 offset write ignored");
    rd_raw(16'h3004, 8'h00, "R2 offset reads zero");
    // priority over arrival order
    wr(1, 8'h02);
    chk(1, 1, 1, "R3 grant loc1");
    wr(0, 8'h02);
    wr(3, 8'h02);
    wr(1, 8'h20);
    chk(0, 1, 1, "R10 last owner held");
    chk(1, 3, 1, "R8 highest not first");
    // combined request+release by owner
    wr(3, 8'h22);
    chk(0, 3, 1, "R5 combined write releases");
    chk(1, 0, 1, "R8 owner not requeued");
    wr(0, 8'h20);
    chk(0, 0, 1, "R9 final release");
    chk(0, 0, 0, "R5 no phantom request");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule